// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the routing and pending state for a bank of interrupt sources and offers deliveries to an interrupt presenter. Each source has a target server, an 8-bit priority, a masked-pending flag, a resend flag and an asserted flag. The asserted flag is sampled from the source's level input. Requests come in on one valid/ready stream that carries three operations: deliver, end-of-interrupt, and configure (set priority and server). Deliveries go out on a second valid/ready stream. The presenter answers each offer with accept or refuse in the same handshake.

A refused offer leaves the source flagged for resend and pulses this bank's bit in the presenter's resend map. A later resend trigger makes the block walk every source, one per cycle, and deliver each flagged one again. A source whose priority is the mask value never reaches the presenter. It is parked as masked-pending and delivered as soon as software writes a real priority. This holds for first deliveries and for resends alike, so masking never loses an interrupt.

Back-pressure rules: `req_ready` is high only while the engine is idle and no resend trigger is present in that cycle. A request is taken on the edge where `req_valid` and `req_ready` are both high. Once `ofr_valid` rises, it and the offered fields hold steady until `ofr_ready` is seen. `ofr_accept` is sampled only on that handshake edge.

Top module: `isc_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF (masked), server 0 and all flags clear; the engine is idle, `busy` and `ofr_valid` are low and `req_ready` is high.
- R2: A deliver request (`req_op`=0) for an unmasked source in the bank produces exactly one offer carrying the global source number (bank base + index), the source's server and its priority; the offer holds its fields until `ofr_ready`.
- R3: A delivery attempt to a source whose priority is 0xFF sets its masked-pending flag and produces no offer.
- R4: A configure request (`req_op`=2) writes priority and server. If it writes a priority other than 0xFF to a masked-pending source, it clears the flag and issues one delivery; otherwise it issues none.
- R5: When the presenter refuses an offer, the source's resend flag is set and `resend_bank_set` pulses high for exactly the handshake cycle. If `pres_need_resend` is high in the following cycle, no retry follows.
- R6: If `pres_need_resend` is low in the cycle after a refusal, the same source is delivered again at once.
- R7: Every delivery attempt first clears the source's resend flag, so a source that was later delivered successfully is not offered by the next scan.
- R8: A pulse on `rescan_req` starts a scan that visits sources in ascending index order and delivers each one flagged for resend. A flagged source that is masked by then becomes masked-pending instead of being offered.
- R9: `busy` is high from the cycle after a request or trigger starts the engine until the engine is idle again, which for a scan means until the scan is finished. `req_ready` is low while `busy` is high or `rescan_req` is high.
- R10: An end-of-interrupt request (`req_op`=1) for a source whose asserted flag is set delivers it again; for a source that is not asserted it does nothing.
- R11: Deliver and end-of-interrupt requests for the reserved IPI source number, or for numbers outside the bank, are consumed with no offer and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Level of each source line, sampled into the asserted flags |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_op | input | 2 | 0 deliver, 1 end-of-interrupt, 2 configure |
| req_src | input | SRC_W | Global source number of the request |
| req_prio | input | 8 | Priority for configure (0xFF masks) |
| req_server | input | SRV_W | Target server for configure |
| rescan_req | input | 1 | Starts a resend scan |
| busy | output | 1 | Engine is delivering or scanning |
| ofr_valid | output | 1 | Offer stream valid |
| ofr_ready | input | 1 | Presenter takes the offer |
| ofr_accept | input | 1 | Presenter verdict on the handshake: 1 accept, 0 refuse |
| pres_need_resend | input | 1 | Presenter's need-resend flag |
| ofr_src | output | SRC_W | Global source number offered |
| ofr_server | output | SRV_W | Target server of the offer |
| ofr_prio | output | 8 | Priority of the offer |
| resend_bank_set | output | 1 | Sets this bank's bit in the presenter's resend map |

## Verification
The bench builds the block with four sources starting at number 8 and places the reserved IPI number at 9, inside the bank. This lets the IPI exclusion be tested on a source that really has state, with its level input high. A four-entry bank keeps each scan to a handful of cycles. That means the final index and the end of scan are reached in every rescan, and the ascending order can be observed with two flagged sources. Numbers 20 and 30 lie outside the bank and exercise the out-of-range path. A scripted presenter model refuses a chosen number of offers and drives its need-resend flag, which covers the retry and no-retry branches.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    OP_DELIVER = 2'd0,
    OP_EOI     = 2'd1,
    OP_CONFIG  = 2'd2,
    OP_RSVD    = 2'd3
  } isc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELIV,
    ST_OFFER,
    ST_CHECK,
    ST_SCAN
  } isc_st_e;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
endpackage

// File: rtl/isc_src_bank.sv
module isc_src_bank #(
  parameter int NUM_SRC = 16,
  parameter int SRV_W   = 6,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            src_level,
  input  logic [IDX_W-1:0]              act_idx,
  input  logic                          cfg_we,
  input  logic [7:0]                    cfg_prio,
  input  logic [SRV_W-1:0]              cfg_srv,
  input  logic                          rs_set,
  input  logic                          rs_clr,
  input  logic                          mp_set,
  input  logic                          mp_clr,
  output logic [NUM_SRC-1:0][7:0]       prio_v,
  output logic [NUM_SRC-1:0][SRV_W-1:0] srv_v,
  output logic [NUM_SRC-1:0]            mpend_v,
  output logic [NUM_SRC-1:0]            resend_v,
  output logic [NUM_SRC-1:0]            asserted_v
);
  import isc_pkg::*;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit = (act_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_v[i]     <= PRIO_MASKED;
        srv_v[i]      <= '0;
        mpend_v[i]    <= 1'b0;
        resend_v[i]   <= 1'b0;
        asserted_v[i] <= 1'b0;
      end else begin
        asserted_v[i] <= src_level[i];
        if (cfg_we && hit) begin
          prio_v[i] <= cfg_prio;
          srv_v[i]  <= cfg_srv;
        end
        if (rs_set && hit)      resend_v[i] <= 1'b1;
        else if (rs_clr && hit) resend_v[i] <= 1'b0;
        if (mp_set && hit)      mpend_v[i] <= 1'b1;
        else if (mp_clr && hit) mpend_v[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/isc_seq.sv
module isc_seq #(
  parameter int NUM_SRC   = 16,
  parameter int SRC_W     = 12,
  parameter int BANK_BASE = 16,
  parameter int IPI_NUM   = 2,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W    = $clog2(NUM_SRC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [7:0]              req_prio,
  output logic                    req_ready,
  input  logic                    rescan_req,
  output logic                    busy,
  output logic                    ofr_valid,
  input  logic                    ofr_ready,
  input  logic                    ofr_accept,
  input  logic                    pres_need_resend,
  output logic                    resend_bank_set,
  input  logic [NUM_SRC-1:0][7:0] prio_v,
  input  logic [NUM_SRC-1:0]      mpend_v,
  input  logic [NUM_SRC-1:0]      resend_v,
  input  logic [NUM_SRC-1:0]      asserted_v,
  output logic [IDX_W-1:0]        act_idx,
  output logic                    cfg_we,
  output logic                    rs_set,
  output logic                    rs_clr,
  output logic                    mp_set,
  output logic                    mp_clr
);
  import isc_pkg::*;

  isc_st_e          st, ret_st;
  logic [IDX_W-1:0] cur;
  logic [CNT_W-1:0] scan_ptr;
  logic             ret_scan;

  logic [SRC_W-1:0] rel;
  logic             in_bank, is_ipi, req_fire, unmask, cur_masked, routable;
  logic [IDX_W-1:0] req_idx;

  assign rel        = req_src - SRC_W'(BANK_BASE);
  assign in_bank    = (req_src >= SRC_W'(BANK_BASE)) && (rel < SRC_W'(NUM_SRC));
  assign req_idx    = rel[IDX_W-1:0];
  assign is_ipi     = (req_src == SRC_W'(IPI_NUM));
  assign routable   = in_bank && !is_ipi;

  assign req_ready  = (st == ST_IDLE) && !rescan_req;
  assign req_fire   = req_valid && req_ready;
  assign busy       = (st != ST_IDLE);
  assign act_idx    = (st == ST_IDLE) ? req_idx : cur;
  assign cur_masked = (prio_v[cur] == PRIO_MASKED);
  assign ret_st     = ret_scan ? ST_SCAN : ST_IDLE;

  assign cfg_we     = req_fire && (req_op == OP_CONFIG) && in_bank;
  assign unmask     = cfg_we && (req_prio != PRIO_MASKED) && mpend_v[req_idx];
  assign mp_clr     = unmask;
  assign rs_clr     = (st == ST_DELIV);
  assign mp_set     = (st == ST_DELIV) && cur_masked;
  assign ofr_valid  = (st == ST_OFFER);
  assign rs_set     = ofr_valid && ofr_ready && !ofr_accept;
  assign resend_bank_set = rs_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      scan_ptr <= '0;
      ret_scan <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rescan_req) begin
            st       <= ST_SCAN;
            scan_ptr <= '0;
          end else if (req_fire) begin
            ret_scan <= 1'b0;
            case (req_op)
              OP_DELIVER: if (routable) begin
                cur <= req_idx;
                st  <= ST_DELIV;
              end
              OP_EOI: if (routable && asserted_v[req_idx]) begin
                cur <= req_idx;
                st  <= ST_DELIV;
              end
              OP_CONFIG: if (unmask) begin
                cur <= req_idx;
                st  <= ST_DELIV;
              end
              default: ;
            endcase
          end
        end
        ST_DELIV: st <= cur_masked ? ret_st : ST_OFFER;
        ST_OFFER: if (ofr_ready) st <= ofr_accept ? ret_st : ST_CHECK;
        ST_CHECK: st <= pres_need_resend ? ret_st : ST_DELIV;
        ST_SCAN: begin
          if (scan_ptr == CNT_W'(NUM_SRC)) begin
            st       <= ST_IDLE;
            ret_scan <= 1'b0;
          end else begin
            scan_ptr <= scan_ptr + 1'b1;
            if (resend_v[scan_ptr[IDX_W-1:0]]) begin
              cur      <= scan_ptr[IDX_W-1:0];
              ret_scan <= 1'b1;
              st       <= ST_DELIV;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl #(
  parameter int NUM_SRC   = 16,
  parameter int SRC_W     = 12,
  parameter int SRV_W     = 6,
  parameter int BANK_BASE = 16,
  parameter int IPI_NUM   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [7:0]         req_prio,
  input  logic [SRV_W-1:0]   req_server,
  input  logic               rescan_req,
  output logic               busy,
  output logic               ofr_valid,
  input  logic               ofr_ready,
  input  logic               ofr_accept,
  input  logic               pres_need_resend,
  output logic [SRC_W-1:0]   ofr_src,
  output logic [SRV_W-1:0]   ofr_server,
  output logic [7:0]         ofr_prio,
  output logic               resend_bank_set
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0][7:0]       prio_v;
  logic [NUM_SRC-1:0][SRV_W-1:0] srv_v;
  logic [NUM_SRC-1:0]            mpend_v, resend_v, asserted_v;
  logic [IDX_W-1:0]              act_idx;
  logic                          cfg_we, rs_set, rs_clr, mp_set, mp_clr;

  isc_src_bank #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .act_idx(act_idx),
    .cfg_we(cfg_we), .cfg_prio(req_prio), .cfg_srv(req_server),
    .rs_set(rs_set), .rs_clr(rs_clr), .mp_set(mp_set), .mp_clr(mp_clr),
    .prio_v(prio_v), .srv_v(srv_v), .mpend_v(mpend_v),
    .resend_v(resend_v), .asserted_v(asserted_v)
  );

  isc_seq #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .BANK_BASE(BANK_BASE), .IPI_NUM(IPI_NUM)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_src(req_src), .req_prio(req_prio), .req_ready(req_ready),
    .rescan_req(rescan_req), .busy(busy), .ofr_valid(ofr_valid),
    .ofr_ready(ofr_ready), .ofr_accept(ofr_accept),
    .pres_need_resend(pres_need_resend), .resend_bank_set(resend_bank_set),
    .prio_v(prio_v), .mpend_v(mpend_v), .resend_v(resend_v),
    .asserted_v(asserted_v), .act_idx(act_idx), .cfg_we(cfg_we),
    .rs_set(rs_set), .rs_clr(rs_clr), .mp_set(mp_set), .mp_clr(mp_clr)
  );

  assign ofr_src    = SRC_W'(BANK_BASE) + SRC_W'(act_idx);
  assign ofr_server = srv_v[act_idx];
  assign ofr_prio   = prio_v[act_idx];
endmodule

// File: rtl/isc_ctrl_chk.sv
module isc_ctrl_chk #(
  parameter int SRC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rescan_req,
  input logic             busy,
  input logic             ofr_valid,
  input logic             ofr_ready,
  input logic             ofr_accept,
  input logic [SRC_W-1:0] ofr_src,
  input logic [7:0]       ofr_prio,
  input logic             resend_bank_set
);
  p_offer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid && !ofr_ready |=> ofr_valid && $stable(ofr_src) && $stable(ofr_prio));

  p_no_masked_offer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid |-> ofr_prio != 8'hFF);

  p_bank_on_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resend_bank_set |-> ofr_valid && ofr_ready && !ofr_accept);

  p_bank_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resend_bank_set |=> !resend_bank_set && !ofr_valid);

  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_scan_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_req && !busy |=> busy);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !rescan_req |-> req_ready);
endmodule

bind isc_ctrl isc_ctrl_chk #(.SRC_W(SRC_W)) u_isc_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rescan_req(rescan_req),
  .busy(busy), .ofr_valid(ofr_valid), .ofr_ready(ofr_ready),
  .ofr_accept(ofr_accept), .ofr_src(ofr_src), .ofr_prio(ofr_prio),
  .resend_bank_set(resend_bank_set)
);

// File: tb/test_isc_ctrl.sv
module test_isc_ctrl;
  localparam int N = 4, SRC_W = 8, SRV_W = 4, BASE = 8, IPI = 9;
  localparam int IW = SRC_W + SRV_W + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_level = '0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [SRC_W-1:0] req_src = '0;
  logic [7:0] req_prio = '0;
  logic [SRV_W-1:0] req_server = '0;
  logic rescan_req = 1'b0, busy;
  logic ofr_valid, ofr_ready = 1'b1, ofr_accept = 1'b1, pres_need_resend = 1'b1;
  logic [SRC_W-1:0] ofr_src;
  logic [SRV_W-1:0] ofr_server;
  logic [7:0] ofr_prio;
  logic resend_bank_set;

  int n_tests = 0, n_fail = 0, rmap_cnt = 0, refuse_left = 0;
  string cur_req = "R2";
  logic [IW-1:0] exp_q[$];

  always #5 clk = ~clk;

  isc_ctrl #(.NUM_SRC(N), .SRC_W(SRC_W), .SRV_W(SRV_W), .BANK_BASE(BASE), .IPI_NUM(IPI)) i_isc_ctrl (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_src(req_src), .req_prio(req_prio),
    .req_server(req_server), .rescan_req(rescan_req), .busy(busy),
    .ofr_valid(ofr_valid), .ofr_ready(ofr_ready), .ofr_accept(ofr_accept),
    .pres_need_resend(pres_need_resend), .ofr_src(ofr_src), .ofr_server(ofr_server),
    .ofr_prio(ofr_prio), .resend_bank_set(resend_bank_set)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic expect_offer(input int src, input int srv, input int prio);
    exp_q.push_back({SRC_W'(src), SRV_W'(srv), 8'(prio)});
  endtask

  task automatic send(input int op, input int src, input int prio, input int srv);
    @(negedge clk);
    req_op = 2'(op); req_src = SRC_W'(src); req_prio = 8'(prio); req_server = SRV_W'(srv);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rescan();
    @(negedge clk);
    rescan_req = 1'b1;
    @(negedge clk);
    rescan_req = 1'b0;
    #1;
    check(busy == 1'b1, "R9", "busy after scan trigger", 32'(busy), 32'd1);
    check(req_ready == 1'b0, "R9", "ready during scan", 32'(req_ready), 32'd0);
  endtask

  task automatic wait_idle(input string req);
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, req, "expected offers left", 32'(exp_q.size()), 32'd0);
  endtask

  // presenter model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (ofr_valid && ofr_ready) begin
        ofr_accept = (refuse_left == 0);
        if (refuse_left > 0) refuse_left--;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected offer", 32'({ofr_src, ofr_server, ofr_prio}), 32'd0);
        end else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          check({ofr_src, ofr_server, ofr_prio} == e, cur_req, "offer {src,srv,prio}",
                32'({ofr_src, ofr_server, ofr_prio}), 32'(e));
        end
        #1;
        if (resend_bank_set) rmap_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int r0;
    src_level = 4'b1010;  // source 11 asserted, IPI source 9 asserted
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    check(ofr_valid == 1'b0, "R1", "offer after reset", 32'(ofr_valid), 32'd0);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);

    // R1 R3: sources start masked, delivery parks the source
    cur_req = "R3";
    send(0, 8, 0, 0);
    wait_idle("R3");

    // R4: unmask delivers the parked source, a second write does not
    cur_req = "R4";
    expect_offer(8, 3, 5);
    send(2, 8, 5, 3);
    wait_idle("R4");
    send(2, 8, 4, 3);
    wait_idle("R4");

    // R2: plain delivery, held under back-pressure
    cur_req = "R2";
    send(2, 10, 7, 2);
    ofr_ready = 1'b0;
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    repeat (2) @(negedge clk);
    #1;
    check(ofr_valid == 1'b1, "R2", "offer held", 32'(ofr_valid), 32'd1);
    check(ofr_src == SRC_W'(10), "R2", "held source", 32'(ofr_src), 32'd10);
    ofr_ready = 1'b1;
    wait_idle("R2");

    // R5: refusal with need-resend high, no retry
    cur_req = "R5";
    r0 = rmap_cnt;
    refuse_left = 1; pres_need_resend = 1'b1;
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    wait_idle("R5");
    check(rmap_cnt == r0 + 1, "R5", "bank resend pulses", 32'(rmap_cnt - r0), 32'd1);

    // R8: scan re-offers the flagged source; R7: second scan finds nothing
    cur_req = "R8";
    expect_offer(10, 2, 7);
    rescan();
    wait_idle("R8");
    cur_req = "R7";
    rescan();
    wait_idle("R7");

    // R6: refusal with need-resend low, immediate retry
    cur_req = "R6";
    r0 = rmap_cnt;
    refuse_left = 1; pres_need_resend = 1'b0;
    expect_offer(8, 3, 4);
    expect_offer(8, 3, 4);
    send(0, 8, 0, 0);
    wait_idle("R6");
    check(rmap_cnt == r0 + 1, "R6", "bank resend pulses", 32'(rmap_cnt - r0), 32'd1);
    pres_need_resend = 1'b1;

    // R7: a later successful delivery clears the resend flag
    cur_req = "R7";
    refuse_left = 1;
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    wait_idle("R7");
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    wait_idle("R7");
    rescan();
    wait_idle("R7");

    // R8: scan order is ascending index
    cur_req = "R8";
    r0 = rmap_cnt;
    refuse_left = 2;
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    wait_idle("R8");
    expect_offer(8, 3, 4);
    send(0, 8, 0, 0);
    wait_idle("R8");
    check(rmap_cnt == r0 + 2, "R8", "bank resend pulses", 32'(rmap_cnt - r0), 32'd2);
    expect_offer(8, 3, 4);
    expect_offer(10, 2, 7);
    rescan();
    wait_idle("R8");

    // R8: flagged source masked before the scan is parked, then unmasked
    refuse_left = 1;
    expect_offer(10, 2, 7);
    send(0, 10, 0, 0);
    wait_idle("R8");
    send(2, 10, 8'hFF, 2);
    rescan();
    wait_idle("R8");
    expect_offer(10, 2, 7);
    send(2, 10, 7, 2);
    wait_idle("R8");

    // R10: end-of-interrupt re-delivers only asserted sources
    cur_req = "R10";
    send(2, 11, 3, 1);
    wait_idle("R10");
    expect_offer(11, 1, 3);
    send(1, 11, 0, 0);
    wait_idle("R10");
    send(1, 10, 0, 0);
    wait_idle("R10");

    // R11: reserved IPI number and out-of-bank numbers are consumed silently
    cur_req = "R11";
    send(2, 9, 2, 0);
    send(0, 9, 0, 0);
    send(1, 9, 0, 0);
    send(0, 20, 0, 0);
    send(1, 30, 0, 0);
    wait_idle("R11");
    #1;
    check(req_ready == 1'b1, "R11", "ready after ignored requests", 32'(req_ready), 32'd1);

    finish_run();
  end
endmodule